// File: doc/BRIEF.md
# Line Oscillator Calibration Controller

This block sequences the start-up and recalibration of a line-rate oscillator that runs at 432 times the line frequency. It divides the oscillator ticks by 432 to produce a one-cycle line pulse. It also holds a protect-frequency request from power-up until the first calibration completes. Calibration is allowed to begin only after the crystal register (subaddress 00) and then the loop-mode register (subaddress 01) have been written.

Once the oscillator has been calibrated, the block watches the coincidence-detector lock flag. It starts a new calibration when lock has been missing for 8 line pulses in a row. It also drives the loop time-constant select and the loop-open control from the register contents and the lock and noise flags. The analog oscillator, the frequency comparator and the phase detector sit outside the block.

Top module: `line_osc_cal`

## Requirements
- R1: `line_pulse` is high for exactly one cycle, in the cycle after every 432nd cycle in which `osc_tick` was high, and is low otherwise.
- R2: `protect_req` is high after reset and stays high until the first calibration completes.
- R3: A `wr_sub0` strobe latches `wr_data[1:0]` onto `xtal_sel` in the next cycle. A `wr_sub1` strobe issued after any `wr_sub0` since reset raises `cal_active` in the next cycle.
- R4: If `cal_active` is high and `freq_reached` is sampled high with no start condition present, then in the next cycle `cal_active` is low and `protect_req` is low.
- R5: While no calibration is active and `protect_req` is low, `cal_active` rises in the cycle after the 8th consecutive `line_pulse` sampled with `locked` low. Any cycle with `locked` high clears the run.
- R6: `tc_sel` reflects `wr_data[1:0]` of the last subaddress-01 write, as follows:
  - 01 forces fast (`tc_sel`=2).
  - 10 forces slow (0).
  - 00 or 11 selects automatic mode. In automatic mode the output is slow (0) when `locked` and `noisy` are both high, and medium (1) otherwise.
- R7: `loop_open` equals `wr_data[2]` of the last subaddress-01 write, and is 0 after reset.
- R8: A `wr_sub1` strobe that arrives before any `wr_sub0` since reset does not start calibration. Its mode bits are still loaded.
- R9: A `por_det` pulse returns every register output to its reset value, and calibration again needs a subaddress 00 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_det | input | 1 | Power-on-reset detected (synchronous) |
| wr_sub0 | input | 1 | Write strobe, subaddress 00 (crystal bits) |
| wr_sub1 | input | 1 | Write strobe, subaddress 01 (loop mode bits) |
| wr_data | input | 3 | Write data for either strobe |
| locked | input | 1 | Coincidence detector reports lock |
| noisy | input | 1 | Input signal is noisy |
| freq_reached | input | 1 | Oscillator has reached its target frequency |
| osc_tick | input | 1 | One oscillator period elapsed |
| protect_req | output | 1 | Hold the oscillator above nominal frequency |
| cal_active | output | 1 | Calibration in progress |
| tc_sel | output | 2 | Loop time constant: 0 slow, 1 medium, 2 fast |
| loop_open | output | 1 | Open the phase loop |
| xtal_sel | output | 2 | Latched crystal indication |
| line_pulse | output | 1 | Line pulse, one per 432 ticks |

## Verification
The bench first writes subaddress 01 before subaddress 00. A design that skipped the ordering rule would start calibration there and drop protection too early. It then runs out-of-lock stretches of exactly 7 line pulses, and runs broken by a single locked cycle. A counter that triggers one pulse early, or that does not restart on relock, shows up as a spurious `cal_active` rise. Sparse and dense tick patterns catch an off-by-one in the divide-by-432. A power-on detect in mid-operation checks that the ordering rule is armed again.

// File: rtl/line_osc_cal.sv
module line_osc_cal #(
  parameter int DIV = 432,
  parameter int OOL_LINES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_det,
  input  logic       wr_sub0,
  input  logic       wr_sub1,
  input  logic [2:0] wr_data,
  input  logic       locked,
  input  logic       noisy,
  input  logic       freq_reached,
  input  logic       osc_tick,
  output logic       protect_req,
  output logic       cal_active,
  output logic [1:0] tc_sel,
  output logic       loop_open,
  output logic [1:0] xtal_sel,
  output logic       line_pulse
);
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(OOL_LINES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OOL_LINES - 1);
  localparam logic [1:0] TC_SLOW = 2'd0, TC_MED = 2'd1, TC_FAST = 2'd2;

  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] ool_cnt;
  logic [1:0]       mode;
  logic             seen0;
  logic             start_wr, ool_trig;

  assign start_wr = wr_sub1 && seen0;
  assign ool_trig = line_pulse && !locked && (ool_cnt == CNT_LAST) && !cal_active && !protect_req;

  assign tc_sel = (mode == 2'b01) ? TC_FAST :
                  (mode == 2'b10) ? TC_SLOW :
                  (locked && noisy) ? TC_SLOW : TC_MED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div        <= '0;
      line_pulse <= 1'b0;
    end else if (osc_tick && div == DIV_LAST) begin
      div        <= '0;
      line_pulse <= 1'b1;
    end else begin
      if (osc_tick) div <= div + 1'b1;
      line_pulse <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ool_cnt <= '0;
    end else if (por_det || locked || cal_active || protect_req) begin
      ool_cnt <= '0;
    end else if (line_pulse) begin
      ool_cnt <= (ool_cnt == CNT_LAST) ? '0 : ool_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect_req <= 1'b1;
      cal_active  <= 1'b0;
      seen0       <= 1'b0;
      mode        <= 2'b00;
      loop_open   <= 1'b0;
      xtal_sel    <= 2'b00;
    end else if (por_det) begin
      protect_req <= 1'b1;
      cal_active  <= 1'b0;
      seen0       <= 1'b0;
      mode        <= 2'b00;
      loop_open   <= 1'b0;
      xtal_sel    <= 2'b00;
    end else begin
      if (wr_sub0) begin
        seen0    <= 1'b1;
        xtal_sel <= wr_data[1:0];
      end
      if (wr_sub1) begin
        mode      <= wr_data[1:0];
        loop_open <= wr_data[2];
      end
      if (start_wr || ool_trig) begin
        cal_active <= 1'b1;
      end else if (cal_active && freq_reached) begin
        cal_active  <= 1'b0;
        protect_req <= 1'b0;
      end
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) div <= DIV_LAST); // R1
  AST_LINE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> $past(osc_tick)); // R1
  AST_CAL_NEEDS_SUB0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) |-> $past(seen0)); // R8
  AST_CAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active && freq_reached && !wr_sub1 && !por_det |=> !cal_active); // R4
  AST_PROTECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_req) |-> $past(cal_active && freq_reached)); // R2
  AST_RECAL_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) && !$past(wr_sub1) |-> $past(line_pulse && !locked)); // R5
  AST_POR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    por_det |=> protect_req && !cal_active && !loop_open); // R9
endmodule

// File: tb/line_osc_cal_bench.sv
module line_osc_cal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 432;
  localparam int OOL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_det = 1'b0, wr_sub0 = 1'b0, wr_sub1 = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic locked = 1'b0, noisy = 1'b0, freq_reached = 1'b0, osc_tick = 1'b0;
  logic protect_req, cal_active, loop_open, line_pulse;
  logic [1:0] tc_sel, xtal_sel;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int tick_mode = 1;
  int cyc = 0;

  int m_div = 0, m_cnt = 0, m_mode = 0, m_xtal = 0;
  bit m_seen0 = 0, m_prot = 1, m_cal = 0, m_open = 0, m_line = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_osc_cal u_line_osc_cal (
    .clk(clk), .rst_n(rst_n), .por_det(por_det), .wr_sub0(wr_sub0), .wr_sub1(wr_sub1),
    .wr_data(wr_data), .locked(locked), .noisy(noisy), .freq_reached(freq_reached),
    .osc_tick(osc_tick), .protect_req(protect_req), .cal_active(cal_active),
    .tc_sel(tc_sel), .loop_open(loop_open), .xtal_sel(xtal_sel), .line_pulse(line_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_tc();
    if (m_mode == 1) return 2;
    if (m_mode == 2) return 0;
    return (locked && noisy) ? 0 : 1;
  endfunction

  task automatic model_update();
    bit start, trig;
    if (!rst_n) begin
      m_div = 0; m_line = 0; m_cnt = 0; m_prot = 1; m_cal = 0;
      m_seen0 = 0; m_mode = 0; m_open = 0; m_xtal = 0;
      return;
    end
    trig = m_line && !locked && (m_cnt == OOL - 1) && !m_cal && !m_prot;
    if (por_det || locked || m_cal || m_prot) m_cnt = 0;
    else if (m_line) m_cnt = (m_cnt == OOL - 1) ? 0 : m_cnt + 1;
    if (por_det) begin
      m_prot = 1; m_cal = 0; m_seen0 = 0; m_mode = 0; m_open = 0; m_xtal = 0;
    end else begin
      start = wr_sub1 && m_seen0;
      if (wr_sub0) begin m_seen0 = 1; m_xtal = wr_data[1:0]; end
      if (wr_sub1) begin m_mode = wr_data[1:0]; m_open = wr_data[2]; end
      if (start || trig) m_cal = 1;
      else if (m_cal && freq_reached) begin m_cal = 0; m_prot = 0; end
    end
    if (osc_tick && m_div == DIV - 1) begin m_div = 0; m_line = 1; end
    else begin if (osc_tick) m_div++; m_line = 0; end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R1", "line_pulse", line_pulse, m_line);
    chk("R2", "protect_req", protect_req, m_prot);
    chk("R4", "cal_active", cal_active, m_cal);
    chk("R6", "tc_sel", tc_sel, exp_tc());
    chk("R7", "loop_open", loop_open, m_open);
    chk("R3", "xtal_sel", xtal_sel, m_xtal);
    cyc++;
    case (tick_mode)
      0: osc_tick = 1'b0;
      1: osc_tick = 1'b1;
      default: osc_tick = (cyc % 3) == 0;
    endcase
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(input bit sub, input logic [2:0] d);
    wr_data = d;
    if (sub) wr_sub1 = 1'b1; else wr_sub0 = 1'b1;
    step();
    wr_sub0 = 1'b0; wr_sub1 = 1'b0;
  endtask

  task automatic wait_lines(input int n);
    int seen = 0;
    while (seen < n) begin
      step();
      if (m_line) seen++;
    end
  endtask

  initial begin
    osc_tick = 1'b1;
    run(3);
    chk("R2", "protect after reset", protect_req, 1);
    chk("R1", "line_pulse after reset", line_pulse, 0);
    rst_n = 1'b1;
    run(900);

    write(1'b1, 3'b100);
    chk("R8", "early sub1 leaves cal idle", cal_active, 0);
    chk("R7", "loop_open loaded by early sub1", loop_open, 1);
    run(5);
    chk("R8", "still idle and protected", protect_req, 1);

    write(1'b0, 3'b010);
    chk("R3", "crystal bits latched", xtal_sel, 2);
    write(1'b1, 3'b000);
    chk("R3", "sub1 after sub0 starts cal", cal_active, 1);
    run(20);
    chk("R4", "cal waits for target", cal_active, 1);
    freq_reached = 1'b1;
    step();
    chk("R4", "cal ends on target", cal_active, 0);
    chk("R2", "protect released", protect_req, 0);

    locked = 1'b1; noisy = 1'b1;
    run(4);
    chk("R6", "auto locked noisy is slow", tc_sel, 0);
    noisy = 1'b0;
    run(2);
    chk("R6", "auto quiet is medium", tc_sel, 1);
    write(1'b1, 3'b001);
    run(2);
    chk("R6", "forced fast", tc_sel, 2);
    write(1'b1, 3'b110);
    run(2);
    chk("R6", "forced slow", tc_sel, 0);
    chk("R7", "loop_open set", loop_open, 1);
    write(1'b1, 3'b011);
    run(2);

    freq_reached = 1'b0;
    locked = 1'b0;
    wait_lines(OOL - 1);
    run(5);
    chk("R5", "no recal after 7 unlocked lines", cal_active, 0);
    locked = 1'b1; step(); locked = 1'b0;
    wait_lines(OOL - 1);
    run(5);
    chk("R5", "relock restarts the run", cal_active, 0);
    wait_lines(1);
    run(2);
    chk("R5", "recal after 8 unlocked lines", cal_active, 1);
    freq_reached = 1'b1; locked = 1'b1;
    run(3);
    chk("R4", "recal ends", cal_active, 0);

    tick_mode = 2;
    run(3000);
    tick_mode = 0;
    run(50);
    tick_mode = 1;

    por_det = 1'b1; step(); por_det = 1'b0;
    chk("R9", "por restores protect", protect_req, 1);
    chk("R9", "por clears crystal bits", xtal_sel, 0);
    write(1'b1, 3'b000);
    chk("R9", "sub1 after por needs sub0 again", cal_active, 0);
    write(1'b0, 3'b001);
    write(1'b1, 3'b000);
    run(3);
    chk("R2", "protect released after new cal", protect_req, 0);
    run(1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule